// File: doc/BRIEF.md
# Audio Control Register Write Target

This block is a write-only target on a two-wire serial control bus. It holds the eight 8-bit settings of a multi-band audio gain processor: source select, input gain, volume, three tone bands and two speaker attenuators. The block samples the bus clock and data lines with its own system clock and finds the start and stop markers. It answers one fixed device address. It takes a subaddress byte and then stores the data bytes that follow.

The subaddress carries a flag that is set per transfer. When the flag is clear, every data byte rewrites the same register. When it is set, the index steps forward after each byte. The index is four bits wide, so indices 8 to 15 exist but hold nothing. Bytes aimed at those indices are acknowledged and then thrown away, and the index wraps from 15 back to 0.

The register values leave the block as one flat vector. Each register also has a one-cycle write strobe. The block drives the data line through a pull-down enable, which the pad turns into an open-drain output. There is no data stream at the edge of the block, so it has no valid/ready handshake. Every pin is a plain level or pulse.

Top module: `audio_ctl_i2c_target`

## Requirements
- R1: After reset the register slices of `reg_flat` (index k at bits 8k+7:8k) hold 0:0x02, 1:0x0E, 2:0x78, 3:0x07, 4:0x0E, 5:0x0E, 6:0xF8, 7:0xF8.
- R2: After the byte 0x88 (address 7'h44 with write bit 0), the subaddress byte and every data byte of a transfer, `sda_pull` is high during the high phase of the ninth SCL pulse.
- R3: Any other address byte, including 0x89 with the read bit set, gets no acknowledge. All bytes that follow are ignored, with no strobe and no register change, until the next START.
- R4: In the subaddress byte, bit 4 is the step flag and bits 3:0 are the register index. Bits 7:5 have no effect.
- R5: When the step flag is 0, every data byte up to STOP is written to the selected register.
- R6: When the step flag is 1, each data byte after the first goes to the previous index plus one. Bytes whose index is 8 to 15 are acknowledged but change no register and raise no strobe.
- R7: During stepping, index 15 is followed by index 0.
- R8: Each stored byte raises exactly one bit of `wr_stb`, bit k for index k, for one cycle. It is high in the first cycle in which the new value shows on `reg_flat`. A register never changes without its strobe.
- R9: After STOP, bytes clocked without a new START are ignored and get no acknowledge.
- R10: A repeated START in the middle of a transfer begins a new address phase.
- R11: `sda_pull` only rises or falls while the synchronized SCL is low. It is released after the falling SCL edge that ends the acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | High pulls the bus data line low |
| reg_flat | output | 64 | Eight register values, index k at bits 8k+7:8k |
| wr_stb | output | 8 | One-cycle write strobe per register |

## Verification
Each bus edge passes through two synchronizer flops and one edge-detect compare before the byte engine acts on it. As a result, `sda_pull` moves about three system clocks after the SCL fall that causes it. The matching write strobe and the new register value arrive one clock after that. The bench therefore samples the acknowledge halfway through the high phase of the ninth pulse, and checks the release a quarter bit period after that pulse falls. Both points lie well past the latency. Stored bytes are scored by a monitor that reacts to the strobe whenever it arrives and pops the expected index and value from a queue. A final pass checks that the queue is empty and that the registers match the bench's model, which catches writes that were lost or dropped wrongly.

// File: rtl/audio_i2c_pkg.sv
package audio_i2c_pkg;
  localparam int NUM_REGS = 8;
  localparam int DATA_W   = 8;
  localparam int IDX_W    = 4;
  localparam int SEL_W    = $clog2(NUM_REGS);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_DATA,
    PH_SKIP
  } phase_t;

  function automatic logic [DATA_W-1:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h02;
      1:       return 8'h0E;
      2:       return 8'h78;
      3:       return 8'h07;
      4:       return 8'h0E;
      5:       return 8'h0E;
      default: return 8'hF8;
    endcase
  endfunction
endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_prev, sda_prev;

  // Idle bus level is high, so reset to high to avoid a false marker.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/byte_engine.sv
module byte_engine
  import audio_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sda_lvl,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_det,
  input  logic                 stop_det,
  output logic                 sda_pull,
  output phase_t               phase,
  output logic                 wr_req,
  output logic [IDX_W-1:0]     wr_idx,
  output logic [DATA_W-1:0]    wr_data
);
  localparam logic [DATA_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b0};
  localparam int                CNT_W     = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              in_ack;
  logic [IDX_W-1:0]  ptr;
  logic              step_on;
  logic              take_bit;

  assign take_bit = scl_rise && !in_ack && (bit_cnt < CNT_W'(DATA_W)) &&
                    (phase == PH_ADDR || phase == PH_SUB || phase == PH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      shreg    <= '0;
      bit_cnt  <= '0;
      in_ack   <= 1'b0;
      sda_pull <= 1'b0;
      ptr      <= '0;
      step_on  <= 1'b0;
      wr_req   <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_req <= 1'b0;
      if (start_det || stop_det) begin
        phase    <= start_det ? PH_ADDR : PH_IDLE;
        bit_cnt  <= '0;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        if (take_bit) begin
          shreg   <= {shreg[DATA_W-2:0], sda_lvl};
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (scl_fall) begin
          if (in_ack) begin
            in_ack   <= 1'b0;
            sda_pull <= 1'b0;
            bit_cnt  <= '0;
          end else if (bit_cnt == CNT_W'(DATA_W)) begin
            case (phase)
              PH_ADDR: begin
                if (shreg == ADDR_BYTE) begin
                  phase    <= PH_SUB;
                  in_ack   <= 1'b1;
                  sda_pull <= 1'b1;
                end else begin
                  phase <= PH_SKIP;
                end
              end
              PH_SUB: begin
                ptr      <= shreg[IDX_W-1:0];
                step_on  <= shreg[IDX_W];
                phase    <= PH_DATA;
                in_ack   <= 1'b1;
                sda_pull <= 1'b1;
              end
              PH_DATA: begin
                in_ack   <= 1'b1;
                sda_pull <= 1'b1;
                if (ptr < IDX_W'(NUM_REGS)) begin
                  wr_req  <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= shreg;
                end
                if (step_on) ptr <= ptr + 1'b1;
              end
              default: phase <= PH_SKIP;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import audio_i2c_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_req,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [NUM_REGS*DATA_W-1:0]  reg_flat,
  output logic [NUM_REGS-1:0]         wr_stb
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic hit;
    assign hit = wr_req && (wr_idx == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_flat[k*DATA_W +: DATA_W] <= reg_default(k);
        wr_stb[k]                    <= 1'b0;
      end else begin
        wr_stb[k] <= hit;
        if (hit) reg_flat[k*DATA_W +: DATA_W] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/audio_ctl_i2c_target.sv
module audio_ctl_i2c_target
  import audio_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h44,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_in,
  input  logic                       sda_in,
  output logic                       sda_pull,
  output logic [NUM_REGS*DATA_W-1:0] reg_flat,
  output logic [NUM_REGS-1:0]        wr_stb
);
  logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  phase_t            phase;
  logic              wr_req;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;

  bus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_pull(sda_pull), .phase(phase), .wr_req(wr_req),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  ctl_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_idx(wr_idx),
    .wr_data(wr_data), .reg_flat(reg_flat), .wr_stb(wr_stb)
  );
endmodule

// File: rtl/audio_ctl_i2c_target_chk.sv
module audio_ctl_i2c_target_chk
  import audio_i2c_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       scl_lvl,
  input logic                       sda_pull,
  input phase_t                     phase,
  input logic                       wr_req,
  input logic [IDX_W-1:0]           wr_idx,
  input logic [NUM_REGS*DATA_W-1:0] reg_flat,
  input logic [NUM_REGS-1:0]        wr_stb
);
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));

  p_change_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_flat) |-> (wr_stb != '0));

  p_request_gives_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> (wr_stb == (NUM_REGS'(1) << wr_idx[SEL_W-1:0])));

  p_dropped_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_idx < IDX_W'(NUM_REGS)));

  p_pull_rise_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_lvl);

  p_pull_fall_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_lvl);

  p_silent_when_skipping_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP || phase == PH_IDLE) |-> !sda_pull);
endmodule

bind audio_ctl_i2c_target audio_ctl_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_pull(sda_pull),
  .phase(phase), .wr_req(wr_req), .wr_idx(wr_idx), .reg_flat(reg_flat),
  .wr_stb(wr_stb)
);

// File: tb/audio_ctl_i2c_target_test.sv
module audio_ctl_i2c_target_test;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_drv = 1'b1;
  logic        sda_pull;
  logic [63:0] reg_flat;
  logic [7:0]  wr_stb;
  wire         sda_line = sda_drv & ~sda_pull;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0]  model [8];
  logic [10:0] exp_q [$];

  always #4 clk = ~clk;

  audio_ctl_i2c_target uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_pull(sda_pull), .reg_flat(reg_flat), .wr_stb(wr_stb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wait_clk(Q); scl = 1'b1; wait_clk(Q);
    sda_drv = 1'b0; wait_clk(Q); scl = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wait_clk(Q); scl = 1'b1; wait_clk(Q);
    sda_drv = 1'b1; wait_clk(2*Q);
  endtask

  // Sends a byte, samples the acknowledge mid-high and the release after the fall.
  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wait_clk(Q); scl = 1'b1; wait_clk(2*Q); scl = 1'b0; wait_clk(Q);
    end
    sda_drv = 1'b1; wait_clk(Q); scl = 1'b1; wait_clk(Q);
    acked = sda_pull;
    wait_clk(Q); scl = 1'b0; wait_clk(Q);
    check(!sda_pull, "R11 pull released after ack bit", sda_pull, 0);
  endtask

  task automatic expect_write(input int idx, input logic [7:0] v);
    exp_q.push_back({idx[2:0], v});
    model[idx] = v;
  endtask

  task automatic ack_check(input bit got, input bit want, input string tag);
    check(got == want, tag, got, want);
  endtask

  // Scoreboard monitor: every strobe must match the head of the queue.
  always @(negedge clk) begin
    if (rst_n && wr_stb != 8'h00) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 strobe without expected write", wr_stb, 0);
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        check(wr_stb == (8'h01 << e[10:8]), "R8 strobe index", wr_stb, 8'h01 << e[10:8]);
        check(reg_flat[e[10:8]*8 +: 8] == e[7:0], "R5 R6 R7 stored value",
              reg_flat[e[10:8]*8 +: 8], e[7:0]);
      end
    end
  end

  bit done = 1'b0;
  initial begin
    wait_clk(200000);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    bit a;
    model[0] = 8'h02; model[1] = 8'h0E; model[2] = 8'h78; model[3] = 8'h07;
    model[4] = 8'h0E; model[5] = 8'h0E; model[6] = 8'hF8; model[7] = 8'hF8;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    for (int k = 0; k < 8; k++)
      check(reg_flat[k*8 +: 8] == model[k], "R1 reset default", reg_flat[k*8 +: 8], model[k]);
    check(sda_pull == 1'b0, "R1 pull idle after reset", sda_pull, 0);

    // R5: fixed index, three bytes to volume.
    bus_start();
    send_byte(8'h88, a); ack_check(a, 1, "R2 address ack");
    send_byte(8'h02, a); ack_check(a, 1, "R2 subaddress ack");
    expect_write(2, 8'h11); send_byte(8'h11, a); ack_check(a, 1, "R2 data ack");
    expect_write(2, 8'h22); send_byte(8'h22, a);
    expect_write(2, 8'h05); send_byte(8'h05, a);
    bus_stop();

    // R4: bits 7:5 set, flag clear, index 3.
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'hE3, a);
    expect_write(3, 8'h0A); send_byte(8'h0A, a);
    expect_write(3, 8'h0C); send_byte(8'h0C, a);
    bus_stop();

    // R6: stepping from 5; byte at index 8 dropped but acked.
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'h15, a);
    expect_write(5, 8'h31); send_byte(8'h31, a);
    expect_write(6, 8'h32); send_byte(8'h32, a);
    expect_write(7, 8'h33); send_byte(8'h33, a);
    send_byte(8'h34, a); ack_check(a, 1, "R6 dropped byte still acked");
    bus_stop();

    // R7: stepping from 14 wraps to 0 after two dropped bytes.
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'h1E, a);
    send_byte(8'h41, a);
    send_byte(8'h42, a);
    expect_write(0, 8'h01); send_byte(8'h01, a);
    expect_write(1, 8'h06); send_byte(8'h06, a);
    bus_stop();

    // R3: wrong address and read bit give no ack, data ignored.
    bus_start();
    send_byte(8'h8A, a); ack_check(a, 0, "R3 wrong address no ack");
    send_byte(8'h04, a); ack_check(a, 0, "R3 ignored byte no ack");
    send_byte(8'h55, a);
    bus_stop();
    bus_start();
    send_byte(8'h89, a); ack_check(a, 0, "R3 read bit no ack");
    send_byte(8'h04, a);
    bus_stop();

    // R9: bytes after STOP without START are ignored.
    send_byte(8'h88, a); ack_check(a, 0, "R9 no ack without start");
    send_byte(8'h04, a);
    send_byte(8'h66, a);
    bus_stop();

    // R10: repeated START mid-transfer restarts the address phase.
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'h04, a);
    expect_write(4, 8'h09); send_byte(8'h09, a);
    bus_start();
    send_byte(8'h88, a); ack_check(a, 1, "R10 address ack after repeated start");
    send_byte(8'h06, a);
    expect_write(6, 8'h44); send_byte(8'h44, a);
    bus_stop();

    wait_clk(20);
    check(exp_q.size() == 0, "R8 all expected writes seen", exp_q.size(), 0);
    for (int k = 0; k < 8; k++)
      check(reg_flat[k*8 +: 8] == model[k], "R3 R6 final register", reg_flat[k*8 +: 8], model[k]);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule